// File: doc/BRIEF.md
# Stack and Register Data Unit

This unit holds the operand storage of a small accumulator-based processor: a 256-byte internal data RAM and three special registers (accumulator, B and stack pointer). A single access port reaches this storage in one of three ways. A direct byte address selects RAM in the lower half of the address space or a special register in the upper half. An indirect access uses a pointer held in R0 or R1 of the active register bank and can reach every RAM byte. A register access names R0 to R7 of the active bank.

Stack operations run on strobes of their own. The stack shares the RAM with the register banks and grows toward higher addresses. A push first advances the pointer and then stores the byte. A pop presents the byte under the pointer during the strobe cycle and then moves the pointer back. Reads on the access port and on the pop output are combinational. Writes and pointer updates take effect on the rising clock edge. The reset input is asynchronous and active-low, and its release is synchronised inside the block over two clock edges.

Top module: `regdata_unit`

## Requirements
- R1: After reset the accumulator and B read 0x00 and the stack pointer reads 0x07.
- R2: With acc_mode = 01 (direct), an address in 0x00–0x7F reads and writes the RAM byte at that address.
- R3: In direct mode, address 0xE0 reads and writes the accumulator, 0xF0 the B register and 0x81 the stack pointer. The acc_o, b_o and sp_o outputs show the current register values.
- R4: In direct mode, an address of 0x80 or above other than 0xE0, 0xF0 and 0x81 reads 0x00, and a write to it changes nothing.
- R5: With acc_mode = 11 (register), acc_addr[2:0] selects Rn of the bank given by bank_sel. That register is the RAM byte at 8·bank_sel + n.
- R6: With acc_mode = 10 (indirect), acc_addr[0] selects R0 (0) or R1 (1) of the current bank, and the byte held there addresses RAM. Pointers 0x80–0xFF reach RAM, not the special registers.
- R7: A push (push high, pop low) increments the stack pointer and writes push_data to RAM at the new pointer value. The first push after reset lands at 0x08, which is R0 of bank 1.
- R8: During a pop (pop high, push low), pop_data shows the RAM byte at the current pointer, and the pointer is then decremented. A pop at 0x00 wraps the pointer to 0xFF.
- R9: A push with the pointer at 0xFF wraps the pointer to 0x00 and writes RAM byte 0x00.
- R10: With push and pop high together, the pointer and the RAM do not change.
- R11: An access-port write in a cycle where push or pop is high is dropped.
- R12: With acc_mode = 00 (idle), acc_rdata reads 0x00 and acc_we has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Active register bank |
| acc_mode | input | 2 | Access kind: 00 idle, 01 direct, 10 indirect, 11 register |
| acc_we | input | 1 | Write strobe for the access port |
| acc_addr | input | 8 | Direct address, register index [2:0], or pointer select [0] |
| acc_wdata | input | 8 | Access-port write data |
| acc_rdata | output | 8 | Access-port read data (combinational) |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| push_data | input | 8 | Byte to push |
| pop_data | output | 8 | RAM byte at the stack pointer |
| acc_o | output | 8 | Accumulator value |
| b_o | output | 8 | B register value |
| sp_o | output | 8 | Stack pointer value |

## Verification
A stack pointer that goes wrong shows on sp_o on the edge after the stack strobe. It also places later pushed bytes at unexpected RAM addresses, which the bench sees when it reads those addresses back directly. An error in address mapping (wrong bank base, indirect pointer taken from the wrong register, a special-register decode that leaks) shows in the same cycle on acc_rdata, or after one write edge on acc_o, b_o or a RAM read-back. Wrap-around at the pointer limits and collisions between the port and the stack strobes are tested with their own stimulus, because routine traffic never reaches them.

// File: rtl/regdata_pkg.sv
package regdata_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int BANK_W    = 2;
  localparam int REG_IDX_W = 3;

  localparam logic [ADDR_W-1:0] SFR_ACC  = 8'hE0;
  localparam logic [ADDR_W-1:0] SFR_B    = 8'hF0;
  localparam logic [ADDR_W-1:0] SFR_SP   = 8'h81;
  localparam logic [DATA_W-1:0] SP_RESET = 8'h07;

  typedef enum logic [1:0] {
    MODE_IDLE     = 2'b00,
    MODE_DIRECT   = 2'b01,
    MODE_INDIRECT = 2'b10,
    MODE_REG      = 2'b11
  } acc_mode_e;
endpackage

// File: rtl/regdata_rst_sync.sv
module regdata_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/regdata_addr_map.sv
module regdata_addr_map
  import regdata_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int BW  = BANK_W,
  parameter int RIW = REG_IDX_W
) (
  input  acc_mode_e       mode,
  input  logic [AW-1:0]   addr,
  input  logic [BW-1:0]   bank_sel,
  input  logic [AW-1:0]   ptr_val,
  output logic [AW-1:0]   ptr_addr,
  output logic [AW-1:0]   ram_addr,
  output logic            sfr_sel,
  output logic            active
);
  logic [AW-1:0] reg_addr;

  // Bank n spans 8n..8n+7; R0/R1 are the first two bytes of it.
  assign ptr_addr = AW'({bank_sel, RIW'(addr[0])});
  assign reg_addr = AW'({bank_sel, addr[RIW-1:0]});

  always_comb begin
    ram_addr = '0;
    sfr_sel  = 1'b0;
    active   = 1'b1;
    case (mode)
      MODE_DIRECT: begin
        ram_addr = addr;
        sfr_sel  = addr[AW-1];
      end
      MODE_INDIRECT: ram_addr = ptr_val;
      MODE_REG:      ram_addr = reg_addr;
      default:       active   = 1'b0;
    endcase
  end
endmodule

// File: rtl/regdata_ram.sv
module regdata_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b,
  input  logic [AW-1:0] raddr_c,
  output logic [DW-1:0] rdata_c
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
  assign rdata_c = mem_q[raddr_c];
endmodule

// File: rtl/regdata_sfr.sv
module regdata_sfr
  import regdata_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          push,
  input  logic          pop,
  output logic [DW-1:0] sp_inc,
  output logic [DW-1:0] acc_q,
  output logic [DW-1:0] b_q,
  output logic [DW-1:0] sp_q
);
  logic [DW-1:0] acc_d, b_d, sp_d;
  logic          acc_en, b_en, sp_en;
  logic          stack_step;

  assign stack_step = push ^ pop;
  assign sp_inc     = sp_q + 1'b1;

  always_comb begin
    acc_en = wr_en && (wr_addr == SFR_ACC);
    b_en   = wr_en && (wr_addr == SFR_B);
    sp_en  = stack_step || (wr_en && !push && !pop && (wr_addr == SFR_SP));
    acc_d  = wr_data;
    b_d    = wr_data;
    if (stack_step) sp_d = push ? sp_inc : sp_q - 1'b1;
    else            sp_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      b_q   <= '0;
      sp_q  <= SP_RESET;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (b_en)   b_q   <= b_d;
      if (sp_en)  sp_q  <= sp_d;
    end
  end

  always_comb begin
    case (rd_addr)
      SFR_ACC: rd_data = acc_q;
      SFR_B:   rd_data = b_q;
      SFR_SP:  rd_data = sp_q;
      default: rd_data = '0;
    endcase
  end

  AST_SP_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (sp_q == DW'($past(sp_q) + 1'b1))); // R7
  AST_SP_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (sp_q == DW'($past(sp_q) - 1'b1))); // R8
  AST_SP_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(sp_q)); // R10
endmodule

// File: rtl/regdata_unit.sv
module regdata_unit
  import regdata_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bank_sel,
  input  logic [1:0]  acc_mode,
  input  logic        acc_we,
  input  logic [7:0]  acc_addr,
  input  logic [7:0]  acc_wdata,
  output logic [7:0]  acc_rdata,
  input  logic        push,
  input  logic        pop,
  input  logic [7:0]  push_data,
  output logic [7:0]  pop_data,
  output logic [7:0]  acc_o,
  output logic [7:0]  b_o,
  output logic [7:0]  sp_o
);
  acc_mode_e         mode;
  logic              srst_n;
  logic [ADDR_W-1:0] ptr_addr, ram_addr;
  logic [DATA_W-1:0] ptr_val, ram_rd, sfr_rd, sp_inc;
  logic              sfr_sel, active;
  logic              stack_busy, push_only, port_we;
  logic              ram_we, sfr_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  assign mode = acc_mode_e'(acc_mode);

  regdata_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  regdata_addr_map #(.AW(ADDR_W), .BW(BANK_W), .RIW(REG_IDX_W)) map_i (
    .mode(mode), .addr(acc_addr), .bank_sel(bank_sel), .ptr_val(ptr_val),
    .ptr_addr(ptr_addr), .ram_addr(ram_addr), .sfr_sel(sfr_sel), .active(active)
  );

  // Stack strobes own the cycle; the port write waits for a quiet one.
  assign stack_busy = push | pop;
  assign push_only  = push & ~pop;
  assign port_we    = acc_we & active & ~stack_busy;
  assign sfr_we     = port_we & sfr_sel;
  assign ram_we     = push_only | (port_we & ~sfr_sel);
  assign ram_waddr  = push_only ? sp_inc    : ram_addr;
  assign ram_wdata  = push_only ? push_data : acc_wdata;

  regdata_ram #(.DW(DATA_W), .AW(ADDR_W)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr_a(ram_addr), .rdata_a(ram_rd),
    .raddr_b(ptr_addr), .rdata_b(ptr_val),
    .raddr_c(sp_o),     .rdata_c(pop_data)
  );

  regdata_sfr #(.DW(DATA_W), .AW(ADDR_W)) sfr_i (
    .clk(clk), .rst_n(srst_n),
    .wr_en(sfr_we), .wr_addr(acc_addr), .wr_data(acc_wdata),
    .rd_addr(acc_addr), .rd_data(sfr_rd),
    .push(push), .pop(pop), .sp_inc(sp_inc),
    .acc_q(acc_o), .b_q(b_o), .sp_q(sp_o)
  );

  always_comb begin
    if (!active)     acc_rdata = '0;
    else if (sfr_sel) acc_rdata = sfr_rd;
    else             acc_rdata = ram_rd;
  end

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_mode == 2'b00) |-> (acc_rdata == 8'h00)); // R12
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    ((acc_mode == 2'b01) && acc_addr[7] && (acc_addr != 8'hE0) &&
     (acc_addr != 8'hF0) && (acc_addr != 8'h81)) |-> (acc_rdata == 8'h00)); // R4
  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!srst_n)
    (push && !pop) |=> (pop_data == $past(push_data))); // R7
  AST_STACK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    ((push || pop) && acc_we && (acc_mode == 2'b01) && (acc_addr == 8'hE0))
    |=> $stable(acc_o)); // R11
  AST_REG_IN_BANK: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_mode == 2'b11) |-> ((ram_addr[7:5] == 3'b000) &&
                             (ram_addr[4:3] == bank_sel))); // R5
endmodule

// File: tb/regdata_unit_tb.sv
`timescale 1ns/1ps
module regdata_unit_tb_top;
  typedef struct packed {
    logic [3:0] req;
    logic [1:0] mode;
    logic       we;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       push;
    logic       pop;
    logic [7:0] pdata;
    logic [1:0] bank;
    logic       chk_rd;
    logic [7:0] exp_rd;
    logic       chk_pop;
    logic [7:0] exp_pop;
    logic [7:0] exp_sp;
  } vec_t;

  localparam int NV = 36;
  // req, mode, we, addr, wdata, push, pop, pdata, bank, chk_rd, exp_rd, chk_pop, exp_pop, exp_sp
  localparam vec_t VECS [NV] = '{
    '{4'd2, 2'd1, 1'b1, 8'h10, 8'h5A, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h07}, // R2
    '{4'd2, 2'd1, 1'b0, 8'h10, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h5A, 1'b0, 8'h00, 8'h07},
    '{4'd2, 2'd1, 1'b1, 8'h7F, 8'hC3, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h07},
    '{4'd2, 2'd1, 1'b0, 8'h7F, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'hC3, 1'b0, 8'h00, 8'h07},
    '{4'd3, 2'd1, 1'b1, 8'hE0, 8'h11, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h07}, // R3
    '{4'd3, 2'd1, 1'b0, 8'hE0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h11, 1'b0, 8'h00, 8'h07},
    '{4'd3, 2'd1, 1'b1, 8'hF0, 8'h22, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h07},
    '{4'd3, 2'd1, 1'b0, 8'hF0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h22, 1'b0, 8'h00, 8'h07},
    '{4'd3, 2'd1, 1'b1, 8'h81, 8'h30, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h30},
    '{4'd3, 2'd1, 1'b0, 8'h81, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h30, 1'b0, 8'h00, 8'h30},
    '{4'd4, 2'd1, 1'b1, 8'h90, 8'hFF, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h30}, // R4
    '{4'd4, 2'd1, 1'b0, 8'h90, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h30},
    '{4'd4, 2'd1, 1'b0, 8'hE0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h11, 1'b0, 8'h00, 8'h30},
    '{4'd4, 2'd1, 1'b0, 8'hF0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h22, 1'b0, 8'h00, 8'h30},
    '{4'd5, 2'd3, 1'b1, 8'h03, 8'hA5, 1'b0, 1'b0, 8'h00, 2'd2, 1'b0, 8'h00, 1'b0, 8'h00, 8'h30}, // R5
    '{4'd5, 2'd1, 1'b0, 8'h13, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'hA5, 1'b0, 8'h00, 8'h30},
    '{4'd5, 2'd3, 1'b1, 8'h03, 8'h3C, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h30},
    '{4'd5, 2'd3, 1'b0, 8'h03, 8'h00, 1'b0, 1'b0, 8'h00, 2'd2, 1'b1, 8'hA5, 1'b0, 8'h00, 8'h30},
    '{4'd5, 2'd3, 1'b0, 8'h03, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h3C, 1'b0, 8'h00, 8'h30},
    '{4'd6, 2'd3, 1'b1, 8'h01, 8'h10, 1'b0, 1'b0, 8'h00, 2'd1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h30}, // R6
    '{4'd6, 2'd2, 1'b0, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 2'd1, 1'b1, 8'h5A, 1'b0, 8'h00, 8'h30},
    '{4'd6, 2'd3, 1'b1, 8'h00, 8'hE0, 1'b0, 1'b0, 8'h00, 2'd1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h30},
    '{4'd6, 2'd2, 1'b1, 8'h00, 8'h77, 1'b0, 1'b0, 8'h00, 2'd1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h30},
    '{4'd6, 2'd2, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 2'd1, 1'b1, 8'h77, 1'b0, 8'h00, 8'h30},
    '{4'd6, 2'd1, 1'b0, 8'hE0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h11, 1'b0, 8'h00, 8'h30},
    '{4'd7, 2'd0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h44, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h31}, // R7
    '{4'd7, 2'd0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h55, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h32},
    '{4'd8, 2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 2'd0, 1'b0, 8'h00, 1'b1, 8'h55, 8'h31}, // R8
    '{4'd8, 2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 2'd0, 1'b0, 8'h00, 1'b1, 8'h44, 8'h30},
    '{4'd10,2'd0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 8'h99, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h30}, // R10
    '{4'd10,2'd1, 1'b0, 8'h31, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h44, 1'b0, 8'h00, 8'h30},
    '{4'd11,2'd1, 1'b1, 8'hE0, 8'hEE, 1'b1, 1'b0, 8'h66, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h31}, // R11
    '{4'd11,2'd1, 1'b0, 8'hE0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h11, 1'b0, 8'h00, 8'h31},
    '{4'd11,2'd1, 1'b1, 8'h81, 8'h00, 1'b0, 1'b1, 8'h00, 2'd0, 1'b0, 8'h00, 1'b1, 8'h66, 8'h30},
    '{4'd12,2'd0, 1'b1, 8'hE0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h30}, // R12
    '{4'd12,2'd1, 1'b0, 8'hE0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h11, 1'b0, 8'h00, 8'h30}
  };

  logic       clk, rst_n;
  logic [1:0] bank_sel, acc_mode;
  logic       acc_we, push, pop;
  logic [7:0] acc_addr, acc_wdata, push_data;
  logic [7:0] acc_rdata, pop_data, acc_o, b_o, sp_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  regdata_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .acc_mode(acc_mode),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .push(push), .pop(pop), .push_data(push_data),
    .pop_data(pop_data), .acc_o(acc_o), .b_o(b_o), .sp_o(sp_o)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic w, input logic [7:0] a,
                       input logic [7:0] wd, input logic pu, input logic po,
                       input logic [7:0] pd, input logic [1:0] bk);
    acc_mode = m; acc_we = w; acc_addr = a; acc_wdata = wd;
    push = pu; pop = po; push_data = pd; bank_sel = bk;
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive(2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0);
    do_reset();

    // R1: reset values
    #1;
    check("R1 acc", acc_o, 8'h00);
    check("R1 b", b_o, 8'h00);
    check("R1 sp", sp_o, 8'h07);
    @(negedge clk);
    drive(2'd1, 1'b0, 8'h81, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0);
    #1 check("R1 sp via port", acc_rdata, 8'h07);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      drive(v.mode, v.we, v.addr, v.wdata, v.push, v.pop, v.pdata, v.bank);
      #1;
      if (v.chk_rd)  check($sformatf("R%0d rdata v%0d", v.req, i), acc_rdata, v.exp_rd);
      if (v.chk_pop) check($sformatf("R%0d pop_data v%0d", v.req, i), pop_data, v.exp_pop);
      @(posedge clk);
      #1 check($sformatf("R%0d sp v%0d", v.req, i), sp_o, v.exp_sp);
    end

    // R3: register outputs follow the port writes
    check("R3 acc_o", acc_o, 8'h11);
    check("R3 b_o", b_o, 8'h22);

    // R7: first push after reset lands at 0x08 (R0 of bank 1)
    do_reset();
    @(negedge clk);
    drive(2'd0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'hAB, 2'd0);
    @(posedge clk);
    #1 check("R7 first push sp", sp_o, 8'h08);
    @(negedge clk);
    drive(2'd1, 1'b0, 8'h08, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0);
    #1 check("R7 first push byte", acc_rdata, 8'hAB);
    @(negedge clk);
    drive(2'd3, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 2'd1);
    #1 check("R7 bank1 R0", acc_rdata, 8'hAB);

    // R9: push wraps 0xFF -> 0x00
    @(negedge clk);
    drive(2'd1, 1'b1, 8'h81, 8'hFF, 1'b0, 1'b0, 8'h00, 2'd0);
    @(posedge clk);
    #1 check("R9 sp preset", sp_o, 8'hFF);
    @(negedge clk);
    drive(2'd0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'hCD, 2'd0);
    @(posedge clk);
    #1 check("R9 sp wrap", sp_o, 8'h00);
    @(negedge clk);
    drive(2'd1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0);
    #1 check("R9 byte at 0x00", acc_rdata, 8'hCD);

    // R8: pop at 0x00 wraps to 0xFF
    @(negedge clk);
    drive(2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 2'd0);
    #1 check("R8 pop_data at 0x00", pop_data, 8'hCD);
    @(posedge clk);
    #1 check("R8 sp wrap", sp_o, 8'hFF);

    @(negedge clk);
    drive(2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0);
    done = 1'b1;
    finish_run();
  end
endmodule